// File: doc/BRIEF.md
# Balanced Ternary Magnitude-Line Decoder

This block takes a signed number written as three balanced-ternary digits (weights 1, 3 and 9, so the range is -13 to +13) and turns it into fourteen signed output lines numbered 0 to 13. The line whose number equals the magnitude of the input carries the sign of the input. Every other line carries zero. A value of +k and a value of -k therefore pick the same line with opposite polarity, and an input of zero lights line 0 with a positive digit.

Each input digit and each output line uses a two-bit code: 11 means -1, 00 means 0 and 01 means +1. The fourth code, 10, is illegal on the input. When any input digit holds it, all lines go quiet and an error flag is raised. The decode logic is combinational: a one-hot split of each digit, a pair of mirrored AND terms per line, and packing into the two-bit code. It is followed by one output register that has a synchronous active-low reset.

Top module: `tdec3_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, every line and err_o read zero after that edge.
- R2: Input digit i sits at trits_i[2i+1:2i] with weight 3^i, and output line k sits at lines_o[2k+1:2k]. Both use the code 11 = -1, 00 = 0, 01 = +1, and no line ever shows 10.
- R3: An input of all-zero digits drives line 0 to 01 and every other line to 00.
- R4: A legal input with positive value v drives line v to 01.
- R5: A legal input with negative value v drives line |v| to 11. Line 0 is never driven to 11.
- R6: For any input, at most one line is nonzero. For a legal input, exactly one line is nonzero and err_o is low.
- R7: If any input digit holds the code 10, every line reads 00 and err_o reads 1.
- R8: The outputs reflect the input sampled at the previous rising clock edge, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trits_i | input | 6 | Three input digits, two bits each, least significant digit in the low bits |
| lines_o | output | 28 | Fourteen output lines, two bits each, line 0 in the low bits |
| err_o | output | 1 | High when the previous input held an illegal digit code |

## Verification
The checker watches several properties on every cycle. It checks that at most one line is nonzero and that no line ever shows the illegal code. It checks that line 0 never goes negative, that an illegal input is followed by the error flag and silent lines, that a legal input is followed by exactly one nonzero line, and that reset clears everything. None of these properties pins down which line is chosen or which sign it carries. Only the bench's full sweep of all 27 legal values can show that, by comparing each result against an expected line and sign worked out from the input value. The sample taken just before a clock edge, which confirms the one-cycle latency, also relies on the bench's scenarios.

// File: rtl/tdec_pkg.sv
// Package: shared codes and the balanced-ternary digit helper for the decoder.
// Assumes two-bit digit codes: 11 = -1, 00 = 0, 01 = +1, 10 = illegal.
package tdec_pkg;
    localparam logic [1:0] TR_NEG  = 2'b11;
    localparam logic [1:0] TR_ZERO = 2'b00;
    localparam logic [1:0] TR_POS  = 2'b01;
    localparam logic [1:0] TR_BAD  = 2'b10;

    // Returns balanced-ternary digit at position pos of a non-negative value.
    function automatic int bt_digit(input int value, input int pos);
        int v;
        int d;
        v = value;
        d = 0;
        for (int j = 0; j <= pos; j++) begin
            d = v % 3;
            if (d == 2) begin
                d = -1;
                v = (v + 1) / 3;
            end else begin
                v = v / 3;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/tdec_trit_split.sv
// Module: splits each two-bit digit code into one-hot flags (neg, zero, pos, bad).
// Assumes the code points of tdec_pkg; exactly one flag is high per digit.
module tdec_trit_split #(
    parameter int N = 3
) (
    input  logic [2*N-1:0] code_i,
    output logic [N-1:0]   neg_o,
    output logic [N-1:0]   zer_o,
    output logic [N-1:0]   pos_o,
    output logic [N-1:0]   bad_o
);
    import tdec_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_digit
        logic [1:0] c;
        assign c = code_i[2*i +: 2];
        // Decode one digit code into its flag.
        always_comb begin
            neg_o[i] = (c == TR_NEG);
            zer_o[i] = (c == TR_ZERO);
            pos_o[i] = (c == TR_POS);
            bad_o[i] = (c == TR_BAD);
        end
    end
endmodule

// File: rtl/tdec_line_terms.sv
// Module: builds, for each output line k, the positive term (input == +k) and the
// mirrored negative term (input == -k) as ANDs of one flag per digit.
// Assumes flags come from tdec_trit_split; line 0 has no negative term.
module tdec_line_terms #(
    parameter int N = 3,
    parameter int L = 14
) (
    input  logic [N-1:0] neg_i,
    input  logic [N-1:0] zer_i,
    input  logic [N-1:0] pos_i,
    output logic [L-1:0] hit_pos_o,
    output logic [L-1:0] hit_neg_o
);
    import tdec_pkg::*;

    for (genvar k = 0; k < L; k++) begin : g_line
        logic [N-1:0] sel_p;
        logic [N-1:0] sel_n;
        for (genvar i = 0; i < N; i++) begin : g_sel
            localparam int D = bt_digit(k, i);
            if (D > 0) begin : g_p
                assign sel_p[i] = pos_i[i];
                assign sel_n[i] = neg_i[i];
            end else if (D < 0) begin : g_n
                assign sel_p[i] = neg_i[i];
                assign sel_n[i] = pos_i[i];
            end else begin : g_z
                assign sel_p[i] = zer_i[i];
                assign sel_n[i] = zer_i[i];
            end
        end
        assign hit_pos_o[k] = &sel_p;
        if (k == 0) begin : g_zero_line
            assign hit_neg_o[k] = 1'b0;
        end else begin : g_signed_line
            assign hit_neg_o[k] = &sel_n;
        end
    end
endmodule

// File: rtl/tdec_out_pack.sv
// Module: packs line hits into two-bit digit codes, blanks them on an illegal input,
// and registers the result. Synchronous active-low reset clears all outputs.
module tdec_out_pack #(
    parameter int L = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [L-1:0]   hit_pos_i,
    input  logic [L-1:0]   hit_neg_i,
    input  logic           bad_i,
    output logic [2*L-1:0] lines_o,
    output logic           err_o
);
    import tdec_pkg::*;

    logic [2*L-1:0] lines_d;

    // Form the next line codes; an illegal input forces every line to zero.
    always_comb begin
        for (int k = 0; k < L; k++) begin
            if (bad_i)             lines_d[2*k +: 2] = TR_ZERO;
            else if (hit_neg_i[k]) lines_d[2*k +: 2] = TR_NEG;
            else if (hit_pos_i[k]) lines_d[2*k +: 2] = TR_POS;
            else                   lines_d[2*k +: 2] = TR_ZERO;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_o <= '0;
            err_o   <= 1'b0;
        end else begin
            lines_o <= lines_d;
            err_o   <= bad_i;
        end
    end
endmodule

// File: rtl/tdec3_top.sv
// Module: balanced-ternary magnitude-line decoder top. Selects line |value| and drives
// it with the sign of the value; one register stage on the outputs.
// Assumes N input digits; L = (3^N + 1) / 2 lines.
module tdec3_top #(
    parameter int N = 3,
    parameter int L = (3**N + 1) / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*N-1:0] trits_i,
    output logic [2*L-1:0] lines_o,
    output logic           err_o
);
    logic [N-1:0] neg;
    logic [N-1:0] zer;
    logic [N-1:0] pos;
    logic [N-1:0] bad;
    logic [L-1:0] hit_pos;
    logic [L-1:0] hit_neg;

    tdec_trit_split #(.N(N)) split_i (
        .code_i (trits_i),
        .neg_o  (neg),
        .zer_o  (zer),
        .pos_o  (pos),
        .bad_o  (bad)
    );

    tdec_line_terms #(.N(N), .L(L)) terms_i (
        .neg_i     (neg),
        .zer_i     (zer),
        .pos_i     (pos),
        .hit_pos_o (hit_pos),
        .hit_neg_o (hit_neg)
    );

    tdec_out_pack #(.L(L)) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_pos_i (hit_pos),
        .hit_neg_i (hit_neg),
        .bad_i     (|bad),
        .lines_o   (lines_o),
        .err_o     (err_o)
    );
endmodule

// File: rtl/tdec3_checker.sv
// Module: property checker for tdec3_top, attached through bind.
// Assumes the port codes of tdec_pkg and one cycle of output latency.
module tdec3_checker #(
    parameter int N = 3,
    parameter int L = 14
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2*N-1:0] trits_i,
    input logic [2*L-1:0] lines_o,
    input logic           err_o
);
    logic [N-1:0] in_bad;
    logic [L-1:0] nz;
    logic [L-1:0] code10;

    for (genvar i = 0; i < N; i++) begin : g_in
        assign in_bad[i] = (trits_i[2*i +: 2] == 2'b10);
    end
    for (genvar k = 0; k < L; k++) begin : g_out
        assign nz[k]     = |lines_o[2*k +: 2];
        assign code10[k] = (lines_o[2*k +: 2] == 2'b10);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (lines_o == '0 && !err_o));

    p_no_code10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        code10 == '0);

    p_zero_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trits_i == '0) |=> (lines_o == {{(2*L-2){1'b0}}, 2'b01}));

    p_line0_not_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lines_o[1:0] != 2'b11);

    p_at_most_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nz));

    p_legal_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bad == '0) |=> ($countones(nz) == 1 && !err_o));

    p_bad_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_bad != '0) |=> (err_o && nz == '0));
endmodule

bind tdec3_top tdec3_checker #(.N(N), .L(L)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trits_i (trits_i),
    .lines_o (lines_o),
    .err_o   (err_o)
);

// File: tb/tdec3_top_tb_top.sv
`timescale 1ns/1ps
module tdec3_top_tb_top;
    localparam int N = 3;
    localparam int L = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] trits_i = '0;
    logic [2*L-1:0] lines_o;
    logic           err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tdec3_top #(.N(N), .L(L)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .trits_i (trits_i),
        .lines_o (lines_o),
        .err_o   (err_o)
    );

    // Directed vectors: {input digits d9,d3,d1 as codes, expected line, expected code}.
    typedef struct packed {
        logic [5:0] din;
        logic [3:0] line;
        logic [1:0] code;
    } vec_t;
    localparam vec_t VECS [8] = '{
        '{6'b00_00_00, 4'd0,  2'b01},
        '{6'b00_00_11, 4'd1,  2'b11},
        '{6'b00_00_01, 4'd1,  2'b01},
        '{6'b00_11_01, 4'd2,  2'b11},
        '{6'b00_01_11, 4'd2,  2'b01},
        '{6'b11_11_11, 4'd13, 2'b11},
        '{6'b01_01_01, 4'd13, 2'b01},
        '{6'b01_00_00, 4'd9,  2'b01}
    };

    // Balanced-ternary code of a value in -13..13, digit i at bits [2i+1:2i].
    function automatic logic [5:0] enc(input int v);
        logic [5:0] r;
        int x;
        int d;
        x = v;
        r = '0;
        for (int i = 0; i < 3; i++) begin
            d = ((x % 3) + 3) % 3;
            if (d == 2) begin
                r[2*i +: 2] = 2'b11;
                x = (x + 1) / 3;
            end else if (d == 1) begin
                r[2*i +: 2] = 2'b01;
                x = (x - 1) / 3;
            end else begin
                r[2*i +: 2] = 2'b00;
                x = x / 3;
            end
        end
        return r;
    endfunction

    function automatic logic [2*L-1:0] expect_lines(input int line, input logic [1:0] code);
        logic [2*L-1:0] e;
        e = '0;
        e[2*line +: 2] = code;
        return e;
    endfunction

    task automatic chk(input string req, input logic [2*L-1:0] act, input logic [2*L-1:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: lines actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic chk_err(input string req, input logic act, input logic exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: err actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    // Drive at the falling edge, then sample 1 ns after the next rising edge.
    task automatic apply(input logic [5:0] d);
        @(negedge clk);
        trits_i = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset with a nonzero input pending.
        trits_i = 6'b01_01_01;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1 reset lines", lines_o, '0);
        chk_err("R1 reset err", err_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3/R4/R5: directed vectors from the table.
        for (int j = 0; j < 8; j++) begin
            apply(VECS[j].din);
            chk("R2 R4 R5 directed", lines_o, expect_lines(int'(VECS[j].line), VECS[j].code));
        end

        // R3: zero input.
        apply(6'b00_00_00);
        chk("R3 zero input", lines_o, expect_lines(0, 2'b01));

        // R4 R5 R6: sweep of all legal values.
        for (int v = -13; v <= 13; v++) begin
            int mag;
            logic [1:0] sg;
            mag = (v < 0) ? -v : v;
            sg  = (v < 0) ? 2'b11 : 2'b01;
            apply(enc(v));
            if (v < 0) chk("R5 sweep negative", lines_o, expect_lines(mag, sg));
            else       chk("R4 sweep positive", lines_o, expect_lines(mag, sg));
            chk_err("R6 sweep err low", err_o, 1'b0);
        end

        // R7: illegal code in each position and in all of them.
        apply(6'b00_00_10);
        chk("R7 bad low digit", lines_o, '0);
        chk_err("R7 bad low digit err", err_o, 1'b1);
        apply(6'b10_01_01);
        chk("R7 bad high digit", lines_o, '0);
        chk_err("R7 bad high digit err", err_o, 1'b1);
        apply(6'b10_10_10);
        chk("R7 all bad", lines_o, '0);
        chk_err("R7 all bad err", err_o, 1'b1);
        apply(6'b01_10_11);
        chk("R7 bad middle digit", lines_o, '0);

        // R6: legal input after an illegal one recovers.
        apply(enc(-7));
        chk("R6 recover after bad", lines_o, expect_lines(7, 2'b11));
        chk_err("R6 recover err", err_o, 1'b0);

        // R8: one-cycle latency; just before the edge the old value still holds.
        @(negedge clk);
        trits_i = enc(11);
        @(posedge clk);
        #1;
        @(negedge clk);
        trits_i = enc(-4);
        #1;
        chk("R8 before edge", lines_o, expect_lines(11, 2'b01));
        @(posedge clk);
        #1;
        chk("R8 after edge", lines_o, expect_lines(4, 2'b11));

        // R1: reset in mid-run clears a live output.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid-run reset", lines_o, '0);
        chk_err("R1 mid-run reset err", err_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        finish_run();
    end
endmodule